// File: doc/BRIEF.md
# Serial Bus Byte Receiver

This block takes one byte from a talker on a three-wire, open-collector serial bus where every line reads low when any party pulls it. A controller pulses `start` once the bus has been turned round to the talker. The receiver then lets go of the clock line and waits for the talker to let the clock float high. Next it releases the data line to say it is ready and starts a window timed in microsecond ticks. If the talker pulls the clock low inside that window, eight bits follow. Each bit is read while the clock is high, least significant bit first. After the eighth clock fall the receiver pulls the data line low to acknowledge the byte.

A talker that holds off past the window marks the byte as the last of its message. The receiver answers the first expiry with a short pull on the data line, records end-of-message, and opens the window again. A second expiry inside the same byte ends the transfer as a read timeout. After an end-of-message byte the receiver waits a further delay and then releases the data line. After an ordinary byte it keeps the data line pulled until the next `start`.

Both line inputs pass through two sampling stages. A level reaches the sequencer only when the two stages agree.

Top module: `serial_byte_rx`

## Requirements
- R1: Reset state: `pull_clk` is 1, `pull_data` is 0, `done` is 0, `status` is 0x00 and `rx_byte` is 0x00.
- R2: `start` releases the clock line on the next edge. `pull_data` keeps its previous value until the filtered clock line reads high, and is released after that.
- R3: Once data is released, a filtered clock low seen before the window of `TIMEOUT_US` ticks expires starts the bit transfer with no end-of-message. A clock low seen in the same cycle as the expiring tick also starts the transfer.
- R4: A first expiry pulls the data line for `EOI_PULSE_US` ticks. The receiver then releases it, records end-of-message and restarts the window.
- R5: A second expiry within the same byte pulses `done` with `status` = 0x42 (bit 6 end-of-message, bit 1 timeout), `rx_byte` = 0x00 and both pull outputs at 0.
- R6: Eight bits are taken least significant first. Each bit is the filtered data level (high = 1) while the clock reads high, and the receiver waits for the clock to go low before the next bit.
- R7: On the eighth clock fall, `pull_data` goes to 1 and `done` is high for exactly one cycle with `rx_byte` valid. For an ordinary byte `status` is 0x00, and the data line stays pulled until the next `start`.
- R8: For an end-of-message byte, `status` is 0x40 and `eoi` is 1. The data line is released `RELEASE_US` ticks after `done`.
- R9: A line level lasting a single clock cycle never reaches the sequencer, because a level is taken only when two consecutive samples agree.
- R10: `start` has no effect except while the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin receiving one byte (honoured when idle) |
| clk_line_in | input | 1 | Sampled bus clock line, 1 = high |
| dat_line_in | input | 1 | Sampled bus data line, 1 = high |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| pull_clk | output | 1 | Drive bus clock line low |
| pull_data | output | 1 | Drive bus data line low |
| rx_byte | output | DATA_W | Last received byte |
| done | output | 1 | One-cycle pulse at the end of a byte |
| eoi | output | 1 | End-of-message seen in the last byte |
| status | output | 8 | 0x00 ok, 0x40 end-of-message, 0x42 read timeout |

## Verification
The talker's clock fall and the expiry of the readiness window can land on the same clock edge, and that edge decides whether a byte is ordinary or end-of-message. The bench stops the free-running tick, issues the window length minus one ticks by hand, and then pulls the clock. It raises the last tick exactly in the cycle in which the filtered clock low first reaches the sequencer. The byte must then arrive with status 0x00 and no acknowledge pulse on the data line before the bits.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_READY,
        S_GO,
        S_EPULSE,
        S_BHI,
        S_BLO,
        S_RELDLY
    } srx_state_e;

    localparam logic [7:0] ST_OK  = 8'h00;
    localparam logic [7:0] ST_EOI = 8'h40;
    localparam logic [7:0] ST_TMO = 8'h02;
endpackage

// File: rtl/srx_line_filter.sv
`timescale 1ns/1ps
module srx_line_filter #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic filt;
    } flt_t;

    flt_t d, q;

    always_comb begin
        d      = q;
        d.s1   = line_in;
        d.s2   = q.s1;
        if (q.s1 == q.s2) begin
            d.filt = q.s2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{s1: RST_VAL, s2: RST_VAL, filt: RST_VAL};
        end else begin
            q <= d;
        end
    end

    assign line_out = q.filt;

    // R9
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.s1 != q.s2) |=> $stable(q.filt));
endmodule

// File: rtl/srx_tick_timer.sv
`timescale 1ns/1ps
module srx_tick_timer #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = tick && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/serial_byte_rx.sv
`timescale 1ns/1ps
module serial_byte_rx #(
    parameter int DATA_W       = 8,
    parameter int TIMEOUT_US   = 256,
    parameter int EOI_PULSE_US = 60,
    parameter int RELEASE_US   = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              clk_line_in,
    input  logic              dat_line_in,
    input  logic              us_tick,
    output logic              pull_clk,
    output logic              pull_data,
    output logic [DATA_W-1:0] rx_byte,
    output logic              done,
    output logic              eoi,
    output logic [7:0]        status
);
    import srx_pkg::*;

    localparam int MAXA = (TIMEOUT_US > EOI_PULSE_US) ? TIMEOUT_US : EOI_PULSE_US;
    localparam int MAXL = (MAXA > RELEASE_US) ? MAXA : RELEASE_US;
    localparam int CW   = $clog2(MAXL + 1);
    localparam int BCW  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int NLINES = 2;

    typedef struct packed {
        srx_state_e        st;
        logic              pclk;
        logic              pdat;
        logic [DATA_W-1:0] sh;
        logic [BCW-1:0]    bcnt;
        logic              eoi_seen;
        logic              done;
        logic [DATA_W-1:0] byte_o;
        logic [7:0]        stat;
    } regs_t;

    regs_t d, q;

    // line conditioning
    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] filt_lines;
    logic              clk_f;
    logic              dat_f;

    assign raw_lines = {dat_line_in, clk_line_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        srx_line_filter #(.RST_VAL(1'b1)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (raw_lines[g]),
            .line_out(filt_lines[g])
        );
    end

    assign clk_f = filt_lines[0];
    assign dat_f = filt_lines[1];

    // shared microsecond timer
    logic          tmr_restart;
    logic          tmr_expired;
    logic [CW-1:0] tmr_limit;

    always_comb begin
        case (q.st)
            S_EPULSE: tmr_limit = CW'(EOI_PULSE_US);
            S_RELDLY: tmr_limit = CW'(RELEASE_US);
            default:  tmr_limit = CW'(TIMEOUT_US);
        endcase
    end

    srx_tick_timer #(.CW(CW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(tmr_restart),
        .tick   (us_tick),
        .limit  (tmr_limit),
        .expired(tmr_expired)
    );

    // sequencer next state
    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.pclk     = 1'b0;
                    d.eoi_seen = 1'b0;
                    d.bcnt     = '0;
                    d.st       = S_READY;
                end
            end
            S_READY: begin
                if (clk_f) begin
                    d.pdat = 1'b0;
                    d.st   = S_GO;
                end
            end
            S_GO: begin
                if (!clk_f) begin
                    d.st = S_BHI;
                end else if (tmr_expired) begin
                    if (q.eoi_seen) begin
                        d.pdat   = 1'b0;
                        d.done   = 1'b1;
                        d.byte_o = '0;
                        d.stat   = ST_EOI | ST_TMO;
                        d.st     = S_IDLE;
                    end else begin
                        d.pdat     = 1'b1;
                        d.eoi_seen = 1'b1;
                        d.st       = S_EPULSE;
                    end
                end
            end
            S_EPULSE: begin
                if (tmr_expired) begin
                    d.pdat = 1'b0;
                    d.st   = S_GO;
                end
            end
            S_BHI: begin
                if (clk_f) begin
                    d.sh = {dat_f, q.sh[DATA_W-1:1]};
                    d.st = S_BLO;
                end
            end
            S_BLO: begin
                if (!clk_f) begin
                    if (q.bcnt == BCW'(DATA_W - 1)) begin
                        d.pdat   = 1'b1;
                        d.done   = 1'b1;
                        d.byte_o = q.sh;
                        d.stat   = q.eoi_seen ? ST_EOI : ST_OK;
                        d.st     = q.eoi_seen ? S_RELDLY : S_IDLE;
                    end else begin
                        d.bcnt = q.bcnt + 1'b1;
                        d.st   = S_BHI;
                    end
                end
            end
            S_RELDLY: begin
                if (tmr_expired) begin
                    d.pdat = 1'b0;
                    d.st   = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    assign tmr_restart = (d.st != q.st);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, pclk: 1'b1, pdat: 1'b0, sh: '0, bcnt: '0,
                   eoi_seen: 1'b0, done: 1'b0, byte_o: '0, stat: ST_OK};
        end else begin
            q <= d;
        end
    end

    assign pull_clk  = q.pclk;
    assign pull_data = q.pdat;
    assign rx_byte   = q.byte_o;
    assign done      = q.done;
    assign status    = q.stat;
    assign eoi       = q.stat[6];

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    ack_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !status[1]) |-> pull_data);

    // R5
    tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status[1]) |-> (!pull_data && !pull_clk && status[6] && rx_byte == '0));

    // R2
    clk_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_clk) |-> $past(start));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != S_IDLE && q.st != S_RELDLY && start) |=> (q.st != S_READY || $past(q.st) == S_READY));
endmodule

// File: tb/sim_serial_byte_rx.sv
`timescale 1ns/1ps
module sim_serial_byte_rx;
    localparam int TMO = 20;
    localparam int EP  = 6;
    localparam int RD  = 6;
    localparam int DIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic auto_tick = 1'b1;
    logic man_tick = 1'b0;
    logic tk_clk = 1'b1;
    logic tk_dat = 1'b0;
    logic glitch = 1'b0;
    int   tick_cnt = 0;

    logic       us_tick, bus_clk, bus_dat;
    logic       pull_clk, pull_data, done, eoi;
    logic [7:0] rx_byte, status;

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit dp_fail = 0;
    bit pc_fail = 0;
    logic done_prev = 1'b0;

    always #2.5 clk = ~clk;

    always @(negedge clk) tick_cnt <= (tick_cnt == DIV - 1) ? 0 : tick_cnt + 1;

    assign us_tick = auto_tick ? (tick_cnt == 0) : man_tick;
    assign bus_clk = glitch ? 1'b1 : !(tk_clk || pull_clk);
    assign bus_dat = !(tk_dat || pull_data);

    serial_byte_rx #(.DATA_W(8), .TIMEOUT_US(TMO), .EOI_PULSE_US(EP), .RELEASE_US(RD)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .clk_line_in(bus_clk),
        .dat_line_in(bus_dat), .us_tick(us_tick), .pull_clk(pull_clk),
        .pull_data(pull_data), .rx_byte(rx_byte), .done(done), .eoi(eoi),
        .status(status)
    );

    // per-clock model: done is a single-cycle pulse, clock is never pulled after the first start
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && done_prev) dp_fail = 1;
            if (started && pull_clk) pc_fail = 1;
        end
        done_prev <= done;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit eoi_mode, input bit coincide,
                             input bit glitch_on, input bit mid_start);
        logic prev;
        int n;
        int w;
        logic [7:0] exp_st;
        prev = pull_data;
        pulse_start();
        started = 1;
        chk(pull_clk == 1'b0, "R2 clock released after start", pull_clk, 0);
        if (glitch_on) begin
            waitc(3);
            glitch = 1'b1;
            @(negedge clk);
            glitch = 1'b0;
            waitc(8);
            chk(pull_data == prev, "R9 one-cycle clock glitch ignored", pull_data, prev);
        end else begin
            waitc(12);
            chk(pull_data == prev, "R2 data kept until clock high", pull_data, prev);
        end
        if (coincide) auto_tick = 1'b0;
        tk_clk = 1'b0;
        n = 0;
        while (pull_data && n < 60) begin @(negedge clk); n++; end
        chk(!pull_data, "R2 data released once clock high", pull_data, 0);
        if (coincide) begin
            for (int k = 0; k < TMO - 1; k++) begin
                man_tick = 1'b1; @(negedge clk);
                man_tick = 1'b0; @(negedge clk);
            end
            tk_clk = 1'b1;
            waitc(3);
            man_tick = 1'b1; @(negedge clk);
            man_tick = 1'b0;
            auto_tick = 1'b1;
            chk(!pull_data, "R3 no acknowledge pulse on coincident edge", pull_data, 0);
        end else if (eoi_mode) begin
            n = 0;
            while (!pull_data && n < TMO * DIV + 40) begin @(negedge clk); n++; end
            chk(pull_data, "R4 end-of-message pulse appears", pull_data, 1);
            w = 0;
            while (pull_data && w < 200) begin @(negedge clk); w++; end
            chk(w >= (EP - 1) * DIV && w <= EP * DIV + 1, "R4 end-of-message pulse length", w, EP * DIV);
            waitc(12);
            tk_clk = 1'b1;
        end else begin
            waitc(12);
            chk(!pull_data, "R3 no pulse before early clock low", pull_data, 0);
            tk_clk = 1'b1;
        end
        for (int i = 0; i < 8; i++) begin
            waitc(8);
            tk_dat = !b[i];
            if (mid_start && i == 3) begin
                pulse_start();
                waitc(6);
            end else begin
                waitc(8);
            end
            tk_clk = 1'b0;
            waitc(8);
            tk_clk = 1'b1;
        end
        tk_dat = 1'b0;
        n = 0;
        while (!done && n < 30) begin @(negedge clk); n++; end
        exp_st = eoi_mode ? 8'h40 : 8'h00;
        chk(done, "R7 done after eighth clock fall", done, 1);
        chk(rx_byte == b, mid_start ? "R10 byte intact despite start" : "R6 byte assembled LSB first", rx_byte, b);
        chk(status == exp_st, eoi_mode ? "R8 status end-of-message" : "R7 status ok", status, exp_st);
        chk(pull_data, "R7 data pulled as acknowledge", pull_data, 1);
        chk(eoi == eoi_mode, "R8 eoi flag", eoi, eoi_mode);
        if (eoi_mode) begin
            w = 0;
            while (pull_data && w < 200) begin @(negedge clk); w++; end
            chk(w >= (RD - 1) * DIV && w <= RD * DIV + 1, "R8 release delay after done", w, RD * DIV);
        end else begin
            waitc(10);
            chk(pull_data, "R7 acknowledge held until next start", pull_data, 1);
        end
    endtask

    task automatic timeout_case();
        int n;
        bit saw;
        logic last;
        pulse_start();
        waitc(4);
        tk_clk = 1'b0;
        n = 0;
        saw = 0;
        last = pull_data;
        while (!done && n < (2 * TMO + EP) * DIV + 80) begin
            @(negedge clk);
            if (pull_data && !last) saw = 1;
            last = pull_data;
            n++;
        end
        chk(saw, "R4 pulse precedes read timeout", saw, 1);
        chk(done, "R5 done on second expiry", done, 1);
        chk(status == 8'h42, "R5 timeout status", status, 8'h42);
        chk(rx_byte == 8'h00, "R5 byte cleared", rx_byte, 0);
        chk(!pull_data, "R5 data released", pull_data, 0);
        tk_clk = 1'b1;
        waitc(10);
    endtask

    initial begin
        waitc(5);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pull_clk == 1'b1, "R1 reset pull_clk", pull_clk, 1);
        chk(pull_data == 1'b0, "R1 reset pull_data", pull_data, 0);
        chk(done == 1'b0, "R1 reset done", done, 0);
        chk(status == 8'h00, "R1 reset status", status, 0);
        chk(rx_byte == 8'h00, "R1 reset byte", rx_byte, 0);
        waitc(4);
        send_byte(8'hA5, 0, 0, 0, 0);
        send_byte(8'h3C, 0, 0, 1, 0);
        send_byte(8'h96, 0, 1, 0, 0);
        send_byte(8'h5A, 1, 0, 0, 0);
        send_byte(8'h81, 0, 0, 0, 1);
        timeout_case();
        send_byte(8'h01, 0, 0, 0, 0);
        chk(!dp_fail, "R7 done lasts one cycle", dp_fail, 0);
        chk(!pc_fail, "R2 clock stays released", pc_fail, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule